// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides, in one combinational step, which of read, write and execute a single memory access may use on a page, and whether the requested access is allowed. It takes the second word of a page table entry, the protection key bits and no-execute flag of the segment that maps the page, the processor's privilege mode, two 64-bit authority mask registers (one for data, one for instruction fetch) and a feature level that says which of those masks the core implements.

Three independent rights sources are combined with a bitwise AND. The first is a small table indexed by the entry's protection value and the selected segment key. The second is the entry's no-execute and guarded bits. The third is a 2-bit field that the entry's class key selects in each authority mask. When the access is denied, the block produces cause bits ready to be written into a data or instruction storage fault status register. Walking the page table and raising the interrupt are done elsewhere.

Top module: `page_perm_check`

## Requirements
- R1: The active key bit is `seg_kp` when `user_mode` is 1 and `seg_ks` when `user_mode` is 0.
- R2: The 3-bit protection value is {`pte_word[63]`, `pte_word[1:0]`}. With key 0, values 0, 1 and 2 grant read, write and execute; values 3 and 6 grant read and execute; 4, 5 and 7 grant nothing.
- R3: With key 1, value 2 grants read, write and execute; values 1 and 3 grant read and execute; 0, 4, 5, 6 and 7 grant nothing.
- R4: If `pte_word[2]` (no-execute) or `pte_word[3]` (guarded) is 1, execute is removed while read and write are unaffected.
- R5: The class key is {`pte_word[61:60]`, `pte_word[11:9]`} (0 to 31). It selects `data_mask[2*(31-k)+1 : 2*(31-k)]`; the upper bit of that field removes write and the lower bit removes read. Level 0 ignores the data mask; levels 1, 2 and 3 apply it.
- R6: At level 2 or 3, the lower bit of the same field of `inst_mask` removes execute; levels 0 and 1 ignore `inst_mask`.
- R7: `rights` is bit 0 read, bit 1 write, bit 2 execute, and equals the AND of the rights from R2/R3, R4, R5 and R6.
- R8: `acc_type` 0 (load) needs read, 1 (store) needs write, 2 (fetch) needs execute, 3 behaves as a load; `granted` is 1 exactly when the needed bit of `rights` is 1 (subject to R9).
- R9: A fetch with `seg_noexec` = 1 is denied with `fetch_cause` = 3'b001 whatever the page rights are; `seg_noexec` has no effect on loads and stores.
- R10: On any other denied fetch, `fetch_cause` bit 0 is set if R4 removed execute, else bit 1 if R2/R3 removed it; bit 2 is set in addition if R6 removed it. `fetch_cause` is 0 for granted accesses and for loads and stores.
- R11: On a denied load or store, `data_cause` bit 0 is set if R2/R3 removed the needed right, bit 1 is set for a store, and bit 2 is set if R5 removed the needed right. `data_cause` is 0 for granted accesses and for fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pte_word | input | 64 | Second word of the matched page table entry |
| seg_kp | input | 1 | Segment key used in user mode |
| seg_ks | input | 1 | Segment key used in supervisor mode |
| seg_noexec | input | 1 | Segment forbids instruction fetch |
| user_mode | input | 1 | 1 when the access is made in user (problem) state |
| data_mask | input | 64 | Data authority mask, two bits per class key |
| inst_mask | input | 64 | Instruction authority mask, two bits per class key |
| feat_level | input | 2 | 0 no masks, 1 data mask, 2 or 3 data and instruction masks |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| rights | output | 3 | Combined rights: bit 0 read, bit 1 write, bit 2 execute |
| granted | output | 1 | Requested access is allowed |
| fetch_cause | output | 3 | Fetch fault cause: bit 0 no-exec/guard, bit 1 protection, bit 2 mask |
| data_cause | output | 3 | Data fault cause: bit 0 protection, bit 1 store, bit 2 mask |

## Verification
The protection table is swept over all eight values for both keys, with the key reached once through the supervisor bit and once through the user bit, which tells a wrong table entry apart from a wrong key select. Class keys at both ends of the range and one with mixed high and low bits each set a single mask bit, showing both the field position and which right each bit removes, and each is repeated at every feature level. Fetches that lose execute to one source, to two sources at once, or to the segment flag pin down the cause priority, and a long run of pseudo-random vectors is compared against a separately written model of all outputs.

// File: rtl/page_perm_pkg.sv
package page_perm_pkg;

  // Field positions inside the entry word (decoded by the page walker too).
  localparam int PP_LO_LSB  = 0;
  localparam int NX_BIT     = 2;
  localparam int GUARD_BIT  = 3;
  localparam int CKEY_LO_LSB = 9;
  localparam int CKEY_HI_LSB = 60;
  localparam int PP_HI_BIT  = 63;

  typedef logic [2:0] rights_t;
  localparam rights_t RT_NONE = 3'b000;
  localparam rights_t RT_RD   = 3'b001;
  localparam rights_t RT_WR   = 3'b010;
  localparam rights_t RT_EX   = 3'b100;
  localparam rights_t RT_ALL  = 3'b111;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALT   = 2'd3
  } acc_e;

  localparam logic [1:0] LVL_BASIC = 2'd0;
  localparam logic [1:0] LVL_DMASK = 2'd1;
  localparam logic [1:0] LVL_IMASK = 2'd2;

  // Rights granted by the protection value for the selected key.
  function automatic rights_t pp_table(input logic key, input logic [2:0] pp);
    rights_t r;
    r = RT_NONE;
    if (!key) begin
      case (pp)
        3'd0, 3'd1, 3'd2: r = RT_ALL;
        3'd3, 3'd6:       r = RT_RD | RT_EX;
        default:          r = RT_NONE;
      endcase
    end else begin
      case (pp)
        3'd2:       r = RT_ALL;
        3'd1, 3'd3: r = RT_RD | RT_EX;
        default:    r = RT_NONE;
      endcase
    end
    return r;
  endfunction

  // Right that an access type must hold.
  function automatic rights_t need_of(input logic [1:0] acc);
    rights_t n;
    case (acc)
      ACC_STORE: n = RT_WR;
      ACC_FETCH: n = RT_EX;
      default:   n = RT_RD;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/pp_rights_unit.sv
module pp_rights_unit
  import page_perm_pkg::*;
(
  input  logic       key_bit,
  input  logic [2:0] pp_val,
  output rights_t    pp_rights
);
  always_comb pp_rights = pp_table(key_bit, pp_val);
endmodule

// File: rtl/class_mask_unit.sv
module class_mask_unit
  import page_perm_pkg::*;
#(
  parameter int KEY_W   = 5,
  parameter int MASK_W  = 2 * (1 << KEY_W),
  parameter bit IS_INST = 1'b0
) (
  input  logic [MASK_W-1:0] mask,
  input  logic [KEY_W-1:0]  class_key,
  input  logic              enable,
  output rights_t           allowed
);
  // Field for key k sits at 2*(NKEYS-1-k); NKEYS-1-k is the bitwise inverse of k.
  logic [KEY_W:0] shift;
  logic [1:0]     field;

  always_comb begin
    shift = {~class_key, 1'b0};
    field = mask[shift +: 2];
  end

  generate
    if (IS_INST) begin : g_inst
      logic unused_wr_bit;
      assign unused_wr_bit = field[1];
      always_comb allowed = (enable && field[0]) ? (RT_RD | RT_WR) : RT_ALL;
    end else begin : g_data
      always_comb begin
        allowed = RT_ALL;
        if (enable) begin
          if (field[1]) allowed = allowed & ~RT_WR;
          if (field[0]) allowed = allowed & ~RT_RD;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/fault_encoder.sv
module fault_encoder
  import page_perm_pkg::*;
(
  input  logic [1:0] acc_type,
  input  logic       seg_noexec,
  input  rights_t    pp_rights,
  input  logic       nxg_ex,
  input  rights_t    dmask_rights,
  input  logic       imask_ex,
  input  rights_t    total_rights,
  output logic       granted,
  output logic [2:0] fetch_cause,
  output logic [2:0] data_cause
);
  rights_t need;

  always_comb begin
    need        = need_of(acc_type);
    granted     = 1'b0;
    fetch_cause = 3'b000;
    data_cause  = 3'b000;
    if (acc_type == ACC_FETCH) begin
      if (seg_noexec) begin
        fetch_cause = 3'b001;
      end else begin
        granted = total_rights[2];
        if (!granted) begin
          fetch_cause[0] = !nxg_ex;
          fetch_cause[1] = nxg_ex && !pp_rights[2];
          fetch_cause[2] = !imask_ex;
        end
      end
    end else begin
      granted = (need & ~total_rights) == RT_NONE;
      if (!granted) begin
        data_cause[0] = |(need & ~pp_rights);
        data_cause[1] = (acc_type == ACC_STORE);
        data_cause[2] = |(need & ~dmask_rights);
      end
    end
  end
endmodule

// File: rtl/page_perm_check.sv
module page_perm_check
  import page_perm_pkg::*;
#(
  parameter int KEY_W  = 5,
  parameter int MASK_W = 2 * (1 << KEY_W)
) (
  input  logic [63:0]       pte_word,
  input  logic              seg_kp,
  input  logic              seg_ks,
  input  logic              seg_noexec,
  input  logic              user_mode,
  input  logic [MASK_W-1:0] data_mask,
  input  logic [MASK_W-1:0] inst_mask,
  input  logic [1:0]        feat_level,
  input  logic [1:0]        acc_type,
  output logic [2:0]        rights,
  output logic              granted,
  output logic [2:0]        fetch_cause,
  output logic [2:0]        data_cause
);
  // Named internal events (observed by the bound checker).
  logic             key_bit;
  logic [2:0]       pp_val;
  logic [KEY_W-1:0] class_key;
  logic             dmask_en;
  logic             imask_en;
  rights_t          pp_rights;
  rights_t          nxg_rights;
  rights_t          dmask_rights;
  rights_t          imask_rights;
  rights_t          total_rights;

  logic unused_entry_bits;
  assign unused_entry_bits = ^{pte_word[62], pte_word[59:12], pte_word[8:4]};

  always_comb begin
    key_bit   = user_mode ? seg_kp : seg_ks;
    pp_val    = {pte_word[PP_HI_BIT], pte_word[PP_LO_LSB +: 2]};
    class_key = KEY_W'({pte_word[CKEY_HI_LSB +: 2], pte_word[CKEY_LO_LSB +: 3]});
    dmask_en  = (feat_level != LVL_BASIC);
    imask_en  = (feat_level >= LVL_IMASK);
    nxg_rights = (pte_word[NX_BIT] || pte_word[GUARD_BIT]) ? (RT_RD | RT_WR) : RT_ALL;
  end

  pp_rights_unit u_pp (
    .key_bit   (key_bit),
    .pp_val    (pp_val),
    .pp_rights (pp_rights)
  );

  class_mask_unit #(.KEY_W(KEY_W), .MASK_W(MASK_W), .IS_INST(1'b0)) u_dmask (
    .mask      (data_mask),
    .class_key (class_key),
    .enable    (dmask_en),
    .allowed   (dmask_rights)
  );

  class_mask_unit #(.KEY_W(KEY_W), .MASK_W(MASK_W), .IS_INST(1'b1)) u_imask (
    .mask      (inst_mask),
    .class_key (class_key),
    .enable    (imask_en),
    .allowed   (imask_rights)
  );

  always_comb total_rights = pp_rights & nxg_rights & dmask_rights & imask_rights;
  assign rights = total_rights;

  logic unused_imask_rw;
  assign unused_imask_rw = ^imask_rights[1:0] ^ ^nxg_rights[1:0];

  fault_encoder u_fault (
    .acc_type     (acc_type),
    .seg_noexec   (seg_noexec),
    .pp_rights    (pp_rights),
    .nxg_ex       (nxg_rights[2]),
    .dmask_rights (dmask_rights),
    .imask_ex     (imask_rights[2]),
    .total_rights (total_rights),
    .granted      (granted),
    .fetch_cause  (fetch_cause),
    .data_cause   (data_cause)
  );
endmodule

// File: rtl/page_perm_props.sv
module page_perm_props (
  input logic [63:0] pte_word,
  input logic        seg_noexec,
  input logic [1:0]  feat_level,
  input logic [1:0]  acc_type,
  input logic [2:0]  rights,
  input logic        granted,
  input logic [2:0]  fetch_cause,
  input logic [2:0]  data_cause,
  input logic [2:0]  pp_rights,
  input logic [2:0]  dmask_rights,
  input logic [2:0]  imask_rights
);
  always_comb begin
    p_segnx_fetch_denied_r9: assert (!(seg_noexec && acc_type == 2'd2) ||
                                     (!granted && fetch_cause == 3'b001))
      else $error("segment no-exec fetch not denied");
    p_rights_within_pp_r7: assert ((rights & ~pp_rights) == 3'b000)
      else $error("rights exceed protection table");
    p_nxg_removes_exec_r4: assert (!(pte_word[2] || pte_word[3]) || !rights[2])
      else $error("execute kept with no-exec/guard");
    p_level0_mask_off_r5: assert (feat_level != 2'd0 || dmask_rights == 3'b111)
      else $error("data mask applied at level 0");
    p_imask_level_r6: assert (feat_level >= 2'd2 || imask_rights == 3'b111)
      else $error("instruction mask applied below level 2");
    p_causes_exclusive_r10: assert (fetch_cause == 3'b000 || data_cause == 3'b000)
      else $error("both cause vectors set");
    p_granted_no_cause_r11: assert (!granted || (fetch_cause == 3'b000 && data_cause == 3'b000))
      else $error("cause reported on granted access");
    p_store_flag_r11: assert (data_cause == 3'b000 || data_cause[1] == (acc_type == 2'd1))
      else $error("store flag mismatch");
    p_nxg_priority_r10: assert (!(fetch_cause[0] && fetch_cause[1]))
      else $error("no-exec and protection reported together");
  end
endmodule

bind page_perm_check page_perm_props u_props (
  .pte_word     (pte_word),
  .seg_noexec   (seg_noexec),
  .feat_level   (feat_level),
  .acc_type     (acc_type),
  .rights       (rights),
  .granted      (granted),
  .fetch_cause  (fetch_cause),
  .data_cause   (data_cause),
  .pp_rights    (pp_rights),
  .dmask_rights (dmask_rights),
  .imask_rights (imask_rights)
);

// File: tb/test_page_perm_check.sv
`timescale 1ns/1ps
module test_page_perm_check;
  logic        clk = 1'b0;
  always #5 clk = ~clk;

  logic [63:0] pte_word;
  logic        seg_kp, seg_ks, seg_noexec, user_mode;
  logic [63:0] data_mask, inst_mask;
  logic [1:0]  feat_level, acc_type;
  logic [2:0]  rights, fetch_cause, data_cause;
  logic        granted;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  page_perm_check i_page_perm_check (
    .pte_word(pte_word), .seg_kp(seg_kp), .seg_ks(seg_ks), .seg_noexec(seg_noexec),
    .user_mode(user_mode), .data_mask(data_mask), .inst_mask(inst_mask),
    .feat_level(feat_level), .acc_type(acc_type), .rights(rights), .granted(granted),
    .fetch_cause(fetch_cause), .data_cause(data_cause)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    pte_word = '0; seg_kp = 0; seg_ks = 0; seg_noexec = 0; user_mode = 0;
    data_mask = '0; inst_mask = '0; feat_level = 2'd0; acc_type = 2'd0;
  endtask

  task automatic settle();
    @(posedge clk); #2;
  endtask

  function automatic logic [63:0] entry(input int pp, input int ck, input bit nx, input bit g);
    logic [63:0] e;
    e = '0;
    e[63] = pp[2]; e[1:0] = pp[1:0];
    e[61:60] = ck[4:3]; e[11:9] = ck[2:0];
    e[2] = nx; e[3] = g;
    return e;
  endfunction

  // Independent model: {rights, granted, fetch_cause, data_cause}
  function automatic logic [9:0] model();
    bit k, rp, wp, xp, nxok, dr, dw, ix, r, w, x, gr, need_ok_pp, need_ok_dm;
    int pp, ck, sh;
    logic [1:0] f, gfield;
    logic [2:0] fc, dc;
    k  = user_mode ? seg_kp : seg_ks;
    pp = {pte_word[63], pte_word[1:0]};
    if (!k) begin
      rp = (pp == 0 || pp == 1 || pp == 2 || pp == 3 || pp == 6);
      wp = (pp <= 2);
    end else begin
      rp = (pp >= 1 && pp <= 3);
      wp = (pp == 2);
    end
    xp = rp;
    nxok = !(pte_word[2] | pte_word[3]);
    ck = {pte_word[61:60], pte_word[11:9]};
    sh = 62 - 2 * ck;
    f = 2'((data_mask >> sh) & 64'd3);
    gfield = 2'((inst_mask >> sh) & 64'd3);
    dr = (feat_level == 0) ? 1'b1 : !f[0];
    dw = (feat_level == 0) ? 1'b1 : !f[1];
    ix = (feat_level >= 2) ? !gfield[0] : 1'b1;
    r = rp & dr; w = wp & dw; x = xp & nxok & ix;
    fc = 0; dc = 0; gr = 0;
    if (acc_type == 2) begin
      if (seg_noexec) fc = 3'b001;
      else begin
        gr = x;
        if (!gr) fc = {!ix, nxok & !xp, !nxok};
      end
    end else begin
      need_ok_pp = (acc_type == 1) ? wp : rp;
      need_ok_dm = (acc_type == 1) ? dw : dr;
      gr = (acc_type == 1) ? w : r;
      if (!gr) dc = {!need_ok_dm, acc_type == 1, !need_ok_pp};
    end
    return {x, w, r, gr, fc, dc};
  endfunction

  task automatic t_idle();
    clear_inputs(); settle();
    chk("R7 idle rights", 16'(rights), 16'h7);
    chk("R8 idle load granted", 16'(granted), 16'h1);
    chk("R10 idle fetch_cause", 16'(fetch_cause), 16'h0);
    chk("R11 idle data_cause", 16'(data_cause), 16'h0);
  endtask

  task automatic t_pp_tables();
    logic [2:0] k0 [8] = '{3'h7, 3'h7, 3'h7, 3'h5, 3'h0, 3'h0, 3'h5, 3'h0};
    logic [2:0] k1 [8] = '{3'h0, 3'h5, 3'h7, 3'h5, 3'h0, 3'h0, 3'h0, 3'h0};
    clear_inputs();
    for (int pp = 0; pp < 8; pp++) begin
      pte_word = entry(pp, 0, 0, 0);
      user_mode = 0; seg_ks = 0; seg_kp = 1; settle();
      chk($sformatf("R2 key0 pp=%0d", pp), 16'(rights), 16'(k0[pp]));
      seg_ks = 1; seg_kp = 0; settle();
      chk($sformatf("R3 key1 pp=%0d", pp), 16'(rights), 16'(k1[pp]));
      user_mode = 1; settle();
      chk($sformatf("R1 user key0 pp=%0d", pp), 16'(rights), 16'(k0[pp]));
      seg_kp = 1; seg_ks = 0; settle();
      chk($sformatf("R1 user key1 pp=%0d", pp), 16'(rights), 16'(k1[pp]));
    end
  endtask

  task automatic t_nxg();
    clear_inputs();
    pte_word = entry(0, 0, 1, 0); settle();
    chk("R4 nx rights", 16'(rights), 16'h3);
    pte_word = entry(0, 0, 0, 1); acc_type = 2; settle();
    chk("R4 guard rights", 16'(rights), 16'h3);
    chk("R10 guard fetch cause", 16'({granted, fetch_cause}), 16'h1);
    acc_type = 1; settle();
    chk("R4 guard store ok", 16'(granted), 16'h1);
  endtask

  task automatic t_data_mask();
    int keys [3] = '{0, 31, 21};
    clear_inputs();
    for (int i = 0; i < 3; i++) begin
      int sh = 62 - 2 * keys[i];
      pte_word = entry(0, keys[i], 0, 0);
      data_mask = 64'd2 << sh;
      for (int lv = 0; lv < 4; lv++) begin
        feat_level = 2'(lv); acc_type = 1; settle();
        chk($sformatf("R5 key%0d wrbit lv%0d rights", keys[i], lv), 16'(rights),
            (lv == 0) ? 16'h7 : 16'h5);
        chk($sformatf("R11 key%0d store lv%0d cause", keys[i], lv), 16'({granted, data_cause}),
            (lv == 0) ? 16'h8 : 16'h6);
      end
      data_mask = 64'd1 << sh; feat_level = 1; acc_type = 0; settle();
      chk($sformatf("R5 key%0d rdbit rights", keys[i]), 16'(rights), 16'h6);
      chk($sformatf("R11 key%0d load cause", keys[i]), 16'({granted, data_cause}), 16'h4);
      acc_type = 3; settle();
      chk($sformatf("R8 key%0d code3 as load", keys[i]), 16'({granted, data_cause}), 16'h4);
      data_mask = ~(64'd3 << sh); acc_type = 0; settle();
      chk($sformatf("R5 key%0d other fields ignored", keys[i]), 16'({rights, granted}), 16'hF);
    end
  endtask

  task automatic t_inst_mask();
    clear_inputs();
    pte_word = entry(0, 7, 0, 0);
    inst_mask = 64'd1 << (62 - 14); acc_type = 2;
    for (int lv = 0; lv < 4; lv++) begin
      feat_level = 2'(lv); settle();
      chk($sformatf("R6 lv%0d rights", lv), 16'(rights), (lv >= 2) ? 16'h3 : 16'h7);
      chk($sformatf("R10 lv%0d fetch", lv), 16'({granted, fetch_cause}), (lv >= 2) ? 16'h4 : 16'h8);
    end
    inst_mask = 64'd2 << (62 - 14); feat_level = 2; settle();
    chk("R6 upper inst bit ignored", 16'({rights, granted}), 16'hF);
  endtask

  task automatic t_seg_nx();
    clear_inputs();
    seg_noexec = 1; acc_type = 2; settle();
    chk("R9 fetch denied", 16'({granted, fetch_cause, data_cause}), 16'h08);
    acc_type = 0; settle();
    chk("R9 load unaffected", 16'({granted, fetch_cause, data_cause}), 16'h40);
    acc_type = 1; settle();
    chk("R9 store unaffected", 16'(granted), 16'h1);
  endtask

  task automatic t_causes();
    clear_inputs();
    seg_ks = 1; pte_word = entry(0, 0, 1, 0); acc_type = 2; feat_level = 2;
    inst_mask = 64'd1 << 62; settle();
    chk("R10 nxg over prot plus mask", 16'(fetch_cause), 16'h5);
    pte_word = entry(0, 0, 0, 0); settle();
    chk("R10 prot plus mask", 16'(fetch_cause), 16'h6);
    inst_mask = '0; settle();
    chk("R10 prot only", 16'({granted, fetch_cause}), 16'h2);
    data_mask = 64'd1 << 62; acc_type = 0; settle();
    chk("R11 prot plus mask load", 16'({granted, data_cause, fetch_cause}), 16'h28);
    data_mask = '0; pte_word = entry(3, 0, 0, 0); acc_type = 1; settle();
    chk("R11 prot store", 16'({granted, data_cause}), 16'h3);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 3000; i++) begin
      pte_word   = {$urandom, $urandom};
      data_mask  = {$urandom, $urandom} & {$urandom, $urandom};
      inst_mask  = {$urandom, $urandom} & {$urandom, $urandom};
      {seg_kp, seg_ks, user_mode} = 3'($urandom);
      seg_noexec = ($urandom % 5) == 0;
      feat_level = 2'($urandom); acc_type = 2'($urandom);
      settle();
      chk($sformatf("R7 R8 R10 R11 sweep %0d", i),
          16'({rights, granted, fetch_cause, data_cause}), 16'(model()));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    t_idle();
    t_pp_tables();
    t_nxg();
    t_data_mask();
    t_inst_mask();
    t_seg_nx();
    t_causes();
    t_sweep();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule